// File: doc/BRIEF.md
# Halfword-Backed 32-bit Memory Bridge

This block sits on the target side of a memory-style expansion card. The host backplane issues byte, halfword and word transfers against what it takes to be a packed, linear 32-bit memory. The memory actually fitted on the card is only 16 bits wide. The bridge hides that difference. A word access is split into two local halfword cycles at consecutive local addresses, upper halfword first. A narrow write becomes a single local cycle with byte enables. A read of any size fetches the whole addressed word, so the host always gets all 32 bits back.

On the host side the requester raises `h_req` with the transfer fields and holds them. The bridge answers with a one-cycle `h_ack` pulse. If the transfer is a block transfer, which the bridge does not support, it answers with a one-cycle `h_nak` pulse instead. The requester drops `h_req` after either pulse.

The local side uses a plain request/ready handshake, and each local cycle may take any number of clocks. Writes can be posted: the host is acknowledged as soon as the write is latched, and the local cycles drain afterwards. Any request that arrives during the drain waits until the drain is finished, so a read that follows a write always sees the new data.

Byte order is big-endian. The byte at word offset 0 travels in host bits 31:24. The byte at an even address sits in local bits 15:8.

Top module: `halfword_bridge`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `h_ack`, `h_nak` and `l_req` are low.
- R2: A read of any size, and a word write, each run exactly two local cycles for word n: local address 2n first, then 2n+1. Bits [1:0] of the byte address are ignored for these.
- R3: A read of any size acknowledges with `h_rdata` = {local halfword 2n, local halfword 2n+1}. Bytes 4n..4n+3 land in bits 31:24, 23:16, 15:8 and 7:0.
- R4: A halfword write (size 1) runs one local cycle at address `h_addr>>1` with `l_be`=11. It writes `h_wdata[31:16]` when `h_addr[1]`=0 and `h_wdata[15:0]` otherwise; `h_addr[0]` is ignored. A byte write (size 0) runs one local cycle at `h_addr>>1`. Its `l_be` is 10 (bits 15:8) for an even address and 01 (bits 7:0) for an odd one, and the byte is taken from the host lane that its offset selects.
- R5: A word write sends `h_wdata[31:16]` to local address 2n and then `h_wdata[15:0]` to 2n+1, both with `l_be`=11 and `l_we`=1.
- R6: `h_size` codes are 0 byte, 1 halfword, 2 word and 3 block. A block request gets a one-cycle `h_nak`, causes no local cycle, and leaves the memory unchanged.
- R7: Every accepted request gets exactly one `h_ack`, lasting one cycle. For a read, the acknowledge comes in the cycle after the second local cycle completes.
- R8: With `POSTED`=1, a write is acknowledged in the cycle after it is accepted, before any of its local cycles completes. With `POSTED`=0, the acknowledge follows the last local cycle.
- R9: A request arriving while earlier local cycles are still draining is not accepted until they finish. A read of a just-written word returns the new data.
- R10: `l_req` stays high, with `l_addr`, `l_be`, `l_we` and `l_wdata` unchanged, until a cycle where `l_rdy` is high.
- R11: The memory is packed and linear: after any mix of writes, local halfword k holds byte address 2k in bits 15:8 and byte address 2k+1 in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_req | input | 1 | Host request, held until ack or nak |
| h_we | input | 1 | 1 = write, 0 = read |
| h_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 block |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 32 | Host write data, big-endian lanes |
| h_ack | output | 1 | One-cycle acknowledge |
| h_nak | output | 1 | One-cycle reject for block requests |
| h_rdata | output | 32 | Full addressed word, valid with a read ack |
| l_req | output | 1 | Local cycle request |
| l_we | output | 1 | Local write enable |
| l_addr | output | ADDR_W-1 | Local halfword address |
| l_be | output | 2 | Local byte enables, bit 1 = bits 15:8 |
| l_wdata | output | 16 | Local write data |
| l_rdata | input | 16 | Local read data, valid with l_rdy |
| l_rdy | input | 1 | Local cycle completes when high with l_req |

## Verification
The hardest situation to reach is a request that arrives while a posted write is still draining. The host has already been acknowledged, so nothing at the host port shows that the bridge is busy. To create this, the bench slows the local model to its longest wait. It then issues a word write and, on the next cycle, a read of the same word. It checks that the read's two local cycles come after the write's two, and that the returned word is the newly written one. Sweeps over every byte, halfword and word address, run with a rotating local latency, cover the lane and enable mapping.

// File: rtl/hwbridge_pkg.sv
package hwbridge_pkg;

  typedef enum logic [1:0] {
    XFER_BYTE  = 2'd0,
    XFER_HALF  = 2'd1,
    XFER_WORD  = 2'd2,
    XFER_BLOCK = 2'd3
  } xfer_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_e;

  // Byte enables of a single narrow local cycle (bit 1 = upper byte lane).
  function automatic logic [1:0] lane_mask(input xfer_e sz, input logic odd);
    if (sz == XFER_BYTE) return odd ? 2'b01 : 2'b10;
    return 2'b11;
  endfunction

  // Host halfword carrying a narrow access, selected by byte-address bit 1.
  function automatic logic [15:0] pick_half(input logic [31:0] w, input logic low);
    return low ? w[15:0] : w[31:16];
  endfunction

  // A transaction needs two local cycles for any read and for word writes.
  function automatic logic needs_pair(input xfer_e sz, input logic we);
    return (!we) || (sz == XFER_WORD);
  endfunction

endpackage

// File: rtl/bridge_decoder.sv
module bridge_decoder
  import hwbridge_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [1:0]        size,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              is_block,
  output logic              pair,
  output logic [ADDR_W-2:0] base,
  output logic [1:0]        be,
  output logic [15:0]       half0,
  output logic [15:0]       half1
);
  localparam int LAW = ADDR_W - 1;

  xfer_e sz;

  always_comb begin
    sz       = xfer_e'(size);
    is_block = (sz == XFER_BLOCK);
    pair     = needs_pair(sz, we);
    if (pair) begin
      base  = {addr[ADDR_W-1:2], 1'b0};
      be    = 2'b11;
      half0 = wdata[31:16];
    end else begin
      base  = addr[ADDR_W-1:1];
      be    = lane_mask(sz, addr[0]);
      half0 = pick_half(wdata, addr[1]);
    end
    half1 = wdata[15:0];
  end

  logic [LAW-1:0] unused_ok;
  assign unused_ok = base;
endmodule

// File: rtl/bridge_read_assembler.sv
module bridge_read_assembler (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap,
  input  logic        second,
  input  logic [15:0] l_rdata,
  output logic [31:0] word
);
  logic [15:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (cap) begin
      if (second) lo_q <= l_rdata;
      else        hi_q <= l_rdata;
    end
  end

  assign word = {hi_q, lo_q};
endmodule

// File: rtl/bridge_sequencer.sv
module bridge_sequencer
  import hwbridge_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter bit POSTED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req,
  input  logic              h_we,
  input  logic              is_block,
  input  logic              pair,
  input  logic [ADDR_W-2:0] base,
  input  logic [1:0]        be,
  input  logic [15:0]       half0,
  input  logic [15:0]       half1,
  input  logic              l_rdy,
  output logic              l_req,
  output logic              l_we,
  output logic [ADDR_W-2:0] l_addr,
  output logic [1:0]        l_be,
  output logic [15:0]       l_wdata,
  output logic              h_ack,
  output logic              h_nak,
  output logic              evt_accept,
  output logic              evt_done,
  output logic              evt_last,
  output logic              op_we,
  output logic              cyc_idx
);
  localparam int LAW = ADDR_W - 1;

  seq_e           state_q;
  logic           pair_q, we_q, idx_q, ack_q, nak_q;
  logic [LAW-1:0] base_q;
  logic [1:0]     be_q;
  logic [15:0]    w0_q, w1_q;
  logic           free, evt_reject, ack_set;

  assign free       = (state_q == SEQ_IDLE) && h_req && !ack_q && !nak_q;
  assign evt_accept = free && !is_block;
  assign evt_reject = free && is_block;
  assign l_req      = (state_q == SEQ_RUN);
  assign evt_done   = l_req && l_rdy;
  assign evt_last   = evt_done && (idx_q == pair_q);

  generate
    if (POSTED) begin : g_posted
      assign ack_set = (evt_accept && h_we) || (evt_last && !we_q);
    end else begin : g_waited
      assign ack_set = evt_last;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pair_q  <= 1'b0;
      we_q    <= 1'b0;
      idx_q   <= 1'b0;
      base_q  <= '0;
      be_q    <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      ack_q   <= 1'b0;
      nak_q   <= 1'b0;
    end else begin
      ack_q <= ack_set;
      nak_q <= evt_reject;
      if (evt_accept) begin
        state_q <= SEQ_RUN;
        pair_q  <= pair;
        we_q    <= h_we;
        idx_q   <= 1'b0;
        base_q  <= base;
        be_q    <= be;
        w0_q    <= half0;
        w1_q    <= half1;
      end else if (evt_last) begin
        state_q <= SEQ_IDLE;
        idx_q   <= 1'b0;
      end else if (evt_done) begin
        idx_q <= 1'b1;
      end
    end
  end

  assign l_we    = we_q;
  assign l_addr  = base_q + {{(LAW-1){1'b0}}, idx_q};
  assign l_be    = be_q;
  assign l_wdata = idx_q ? w1_q : w0_q;
  assign h_ack   = ack_q;
  assign h_nak   = nak_q;
  assign op_we   = we_q;
  assign cyc_idx = idx_q;
endmodule

// File: rtl/halfword_bridge.sv
module halfword_bridge
  import hwbridge_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter bit POSTED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [1:0]        h_size,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic              h_ack,
  output logic              h_nak,
  output logic [31:0]       h_rdata,
  output logic              l_req,
  output logic              l_we,
  output logic [ADDR_W-2:0] l_addr,
  output logic [1:0]        l_be,
  output logic [15:0]       l_wdata,
  input  logic [15:0]       l_rdata,
  input  logic              l_rdy
);
  localparam int LAW = ADDR_W - 1;

  logic           dec_block, dec_pair;
  logic [LAW-1:0] dec_base;
  logic [1:0]     dec_be;
  logic [15:0]    dec_h0, dec_h1;

  // Named internal events, observed by the bound checker.
  logic evt_accept, evt_done, evt_last, op_we, cyc_idx;

  bridge_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .size     (h_size),
    .we       (h_we),
    .addr     (h_addr),
    .wdata    (h_wdata),
    .is_block (dec_block),
    .pair     (dec_pair),
    .base     (dec_base),
    .be       (dec_be),
    .half0    (dec_h0),
    .half1    (dec_h1)
  );

  bridge_sequencer #(.ADDR_W(ADDR_W), .POSTED(POSTED)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_req      (h_req),
    .h_we       (h_we),
    .is_block   (dec_block),
    .pair       (dec_pair),
    .base       (dec_base),
    .be         (dec_be),
    .half0      (dec_h0),
    .half1      (dec_h1),
    .l_rdy      (l_rdy),
    .l_req      (l_req),
    .l_we       (l_we),
    .l_addr     (l_addr),
    .l_be       (l_be),
    .l_wdata    (l_wdata),
    .h_ack      (h_ack),
    .h_nak      (h_nak),
    .evt_accept (evt_accept),
    .evt_done   (evt_done),
    .evt_last   (evt_last),
    .op_we      (op_we),
    .cyc_idx    (cyc_idx)
  );

  bridge_read_assembler u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (evt_done && !op_we),
    .second  (cyc_idx),
    .l_rdata (l_rdata),
    .word    (h_rdata)
  );
endmodule

// File: rtl/halfword_bridge_chk.sv
module halfword_bridge_chk #(
  parameter int ADDR_W = 24,
  parameter bit POSTED = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_we,
  input logic              h_ack,
  input logic              h_nak,
  input logic              l_req,
  input logic              l_rdy,
  input logic              l_we,
  input logic [ADDR_W-2:0] l_addr,
  input logic [1:0]        l_be,
  input logic [15:0]       l_wdata,
  input logic              evt_accept,
  input logic              evt_done,
  input logic              evt_last,
  input logic              op_we
);
  logic [1:0] ndone;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ndone <= '0;
    else if (evt_accept) ndone <= '0;
    else if (evt_done)  ndone <= ndone + 2'd1;
  end

  // R10
  hold_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_req && !l_rdy |=> l_req && $stable(l_addr) && $stable(l_be) && $stable(l_we) && $stable(l_wdata));

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) h_ack |=> !h_ack);

  // R7
  read_ack_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_ack && !op_we |-> $past(evt_last));

  // R2
  read_two_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_last && !op_we |-> ndone == 2'd1);

  // R6
  nak_no_local_chk: assert property (@(posedge clk) disable iff (!rst_n) h_nak |-> !l_req && !h_ack);

  // R6
  nak_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) h_nak |=> !h_nak);

  // R9
  accept_when_drained_chk: assert property (@(posedge clk) disable iff (!rst_n) evt_accept |-> !l_req);

  // R8
  posted_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    POSTED && evt_accept && h_we |=> h_ack);
endmodule

bind halfword_bridge halfword_bridge_chk #(.ADDR_W(ADDR_W), .POSTED(POSTED)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .h_we       (h_we),
  .h_ack      (h_ack),
  .h_nak      (h_nak),
  .l_req      (l_req),
  .l_rdy      (l_rdy),
  .l_we       (l_we),
  .l_addr     (l_addr),
  .l_be       (l_be),
  .l_wdata    (l_wdata),
  .evt_accept (evt_accept),
  .evt_done   (evt_done),
  .evt_last   (evt_last),
  .op_we      (op_we)
);

// File: tb/tb_halfword_bridge.sv
`timescale 1ns/1ps
module tb_halfword_bridge;
  localparam int AW  = 6;
  localparam int LAW = AW - 1;
  localparam int NB  = 1 << AW;
  localparam int NH  = 1 << LAW;
  localparam int NW  = 1 << (AW - 2);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic h_req = 1'b0, h_we = 1'b0;
  logic [1:0] h_size = 2'd0;
  logic [AW-1:0] h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic h_ack, h_nak, l_req, l_we;
  logic [31:0] h_rdata;
  logic [LAW-1:0] l_addr;
  logic [1:0] l_be;
  logic [15:0] l_wdata, l_rdata;
  logic l_rdy = 1'b0;

  halfword_bridge #(.ADDR_W(AW), .POSTED(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_size(h_size),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_ack(h_ack), .h_nak(h_nak),
    .h_rdata(h_rdata), .l_req(l_req), .l_we(l_we), .l_addr(l_addr),
    .l_be(l_be), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rdy(l_rdy)
  );

  // Local memory model with logging of every completed local cycle.
  logic [15:0] mem [NH];
  logic [LAW-1:0] lg_addr [1024];
  logic [1:0]     lg_be   [1024];
  logic           lg_we   [1024];
  logic [15:0]    lg_wd   [1024];
  int lcount = 0;
  assign l_rdata = mem[l_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NH; i++) mem[i] = 16'h0;
    end else if (l_req && l_rdy) begin
      lg_addr[lcount % 1024] = l_addr;
      lg_be[lcount % 1024]   = l_be;
      lg_we[lcount % 1024]   = l_we;
      lg_wd[lcount % 1024]   = l_wdata;
      if (l_we && l_be[1]) mem[l_addr][15:8] = l_wdata[15:8];
      if (l_we && l_be[0]) mem[l_addr][7:0]  = l_wdata[7:0];
      lcount++;
    end
  end

  int lat = 0;
  int wcnt = 0;
  always @(negedge clk) begin
    if (l_rdy) begin
      l_rdy = 1'b0;
      wcnt = 0;
    end else if (l_req) begin
      if (wcnt >= lat) l_rdy = 1'b1;
      else wcnt++;
    end
  end

  logic [7:0] refb [NB];
  int errors = 0, checks = 0, cyc = 0;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung act=%0d exp<150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_word(input int n);
    return {refb[4*n], refb[4*n+1], refb[4*n+2], refb[4*n+3]};
  endfunction

  // One host transaction; returns read data, response kind and local count at response.
  task automatic txn(input logic we, input logic [1:0] sz, input int a, input logic [31:0] wd,
                     output logic [31:0] rd, output bit acked, output bit naked, output int lc);
    int g;
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_size = sz; h_addr = AW'(a); h_wdata = wd;
    acked = 0; naked = 0; g = 0;
    while (!acked && !naked && g < 300) begin
      @(negedge clk);
      acked = h_ack; naked = h_nak; g++;
    end
    rd = h_rdata; lc = lcount;
    h_req = 1'b0;
    chk(acked || naked, "R7", "response received", 32'(g), 32'd300);
    @(negedge clk);
    chk(!h_ack && !h_nak, "R7", "response lasts one cycle", {30'd0, h_ack, h_nak}, 32'd0);
  endtask

  task automatic drain();
    int q = 0;
    while (q < 3) begin
      @(negedge clk);
      if (l_req) q = 0; else q++;
    end
  endtask

  initial begin
    logic [31:0] rd, wd;
    bit ak, nk;
    int lc0, lc;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!h_ack && !h_nak && !l_req, "R1", "outputs in reset", {29'd0, h_ack, h_nak, l_req}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!h_ack && !h_nak && !l_req, "R1", "outputs after reset", {29'd0, h_ack, h_nak, l_req}, 32'd0);
    for (int i = 0; i < NB; i++) refb[i] = 8'h0;

    // R5 R8 word writes over every word, latency rotating
    for (int n = 0; n < NW; n++) begin
      lat = n % 4;
      wd = 32'hA5000000 ^ (32'(n) * 32'h01030507) ^ 32'h0000C33C;
      lc0 = lcount;
      txn(1'b1, 2'd2, 4*n + (n % 4), wd, rd, ak, nk, lc);
      chk(ak && lc == lc0, "R8", "posted ack before local cycles", 32'(lc - lc0), 32'd0);
      drain();
      chk(lcount - lc0 == 2, "R5", "word write local count", 32'(lcount - lc0), 32'd2);
      chk(lg_addr[lc0] == LAW'(2*n) && lg_addr[lc0+1] == LAW'(2*n+1) && lg_we[lc0] && lg_we[lc0+1],
          "R5", "word write addresses", {11'd0, lg_addr[lc0], 11'd0, lg_addr[lc0+1]}, 32'(2*n));
      chk({lg_wd[lc0], lg_wd[lc0+1]} == wd && lg_be[lc0] == 2'b11 && lg_be[lc0+1] == 2'b11,
          "R5", "word write halves", {lg_wd[lc0], lg_wd[lc0+1]}, wd);
      for (int b = 0; b < 4; b++) refb[4*n+b] = wd[31-8*b -: 8];
    end

    // R2 R3 R7 word reads
    for (int n = 0; n < NW; n++) begin
      lat = (n + 1) % 4;
      lc0 = lcount;
      txn(1'b0, 2'd2, 4*n, 32'h0, rd, ak, nk, lc);
      chk(rd == ref_word(n), "R3", "word read data", rd, ref_word(n));
      chk(lc - lc0 == 2, "R7", "read ack after second local cycle", 32'(lc - lc0), 32'd2);
      chk(lg_addr[lc0] == LAW'(2*n) && lg_addr[lc0+1] == LAW'(2*n+1) && !lg_we[lc0],
          "R2", "read order upper first", {11'd0, lg_addr[lc0], 11'd0, lg_addr[lc0+1]}, 32'(2*n));
    end

    // R4 byte writes over every byte address
    for (int a = 0; a < NB; a++) begin
      logic [7:0] bv;
      logic [31:0] m;
      int sh;
      lat = a % 3;
      bv = 8'(a * 7 + 3);
      sh = 8 * (3 - (a % 4));
      m = 32'hFF << sh;
      wd = (32'h5A5A5A5A & ~m) | (32'(bv) << sh);
      lc0 = lcount;
      txn(1'b1, 2'd0, a, wd, rd, ak, nk, lc);
      drain();
      chk(lcount - lc0 == 1 && lg_addr[lc0] == LAW'(a >> 1), "R4", "byte write one cycle at a>>1",
          {11'd0, lg_addr[lc0], 16'(lcount - lc0)}, {11'd0, LAW'(a >> 1), 16'd1});
      chk(lg_be[lc0] == ((a % 2) ? 2'b01 : 2'b10), "R4", "byte enables",
          {30'd0, lg_be[lc0]}, (a % 2) ? 32'd1 : 32'd2);
      chk(((a % 2) ? lg_wd[lc0][7:0] : lg_wd[lc0][15:8]) == bv, "R4", "byte lane data",
          {16'd0, lg_wd[lc0]}, {24'd0, bv});
      refb[a] = bv;
    end

    // R11 packed layout of local memory
    for (int k = 0; k < NH; k++)
      chk(mem[k] == {refb[2*k], refb[2*k+1]}, "R11", "halfword holds bytes 2k,2k+1",
          {16'd0, mem[k]}, {16'd0, refb[2*k], refb[2*k+1]});

    // R3 byte reads return full word
    for (int n = 0; n < NW; n++) begin
      lc0 = lcount;
      txn(1'b0, 2'd0, 4*n + 3 - (n % 4), 32'h0, rd, ak, nk, lc);
      chk(rd == ref_word(n), "R3", "byte read returns full word", rd, ref_word(n));
      chk(lc - lc0 == 2, "R2", "byte read uses two cycles", 32'(lc - lc0), 32'd2);
    end

    // R4 halfword writes, addr bit 0 set on odd halfwords
    for (int h = 0; h < NH; h++) begin
      logic [15:0] hv;
      int a;
      lat = h % 4;
      hv = 16'(h * 16'h1357 + 16'h0101);
      a = 2*h + (h % 2);
      wd = (a & 2) ? {16'hC3C3, hv} : {hv, 16'hC3C3};
      lc0 = lcount;
      txn(1'b1, 2'd1, a, wd, rd, ak, nk, lc);
      drain();
      chk(lcount - lc0 == 1 && lg_addr[lc0] == LAW'(h) && lg_be[lc0] == 2'b11 && lg_wd[lc0] == hv,
          "R4", "halfword write", {lg_addr[lc0], 1'b0, lg_be[lc0], 8'd0, lg_wd[lc0]},
          {LAW'(h), 1'b0, 2'b11, 8'd0, hv});
      refb[2*h] = hv[15:8]; refb[2*h+1] = hv[7:0];
    end

    // R3 halfword reads
    for (int n = 0; n < NW; n++) begin
      txn(1'b0, 2'd1, 4*n + 2 * (n % 2), 32'h0, rd, ak, nk, lc);
      chk(rd == ref_word(n), "R3", "halfword read returns full word", rd, ref_word(n));
    end

    // R6 block write and block read rejected
    lc0 = lcount;
    txn(1'b1, 2'd3, 8, 32'hFFFFFFFF, rd, ak, nk, lc);
    repeat (6) @(negedge clk);
    chk(nk && !ak && lcount == lc0, "R6", "block write rejected, no local cycle",
        {ak, nk, 30'(lcount - lc0)}, {1'b0, 1'b1, 30'd0});
    txn(1'b0, 2'd3, 12, 32'h0, rd, ak, nk, lc);
    repeat (6) @(negedge clk);
    chk(nk && !ak && lcount == lc0, "R6", "block read rejected, no local cycle",
        {ak, nk, 30'(lcount - lc0)}, {1'b0, 1'b1, 30'd0});
    txn(1'b0, 2'd2, 8, 32'h0, rd, ak, nk, lc);
    chk(rd == ref_word(2), "R6", "memory unchanged after block", rd, ref_word(2));

    // R9 read stalled behind a draining posted write to the same word
    lat = 3;
    lc0 = lcount;
    wd = 32'h1BADF00D;
    txn(1'b1, 2'd2, 20, wd, rd, ak, nk, lc);
    for (int b = 0; b < 4; b++) refb[20+b] = wd[31-8*b -: 8];
    chk(l_req, "R9", "write still draining when read issued", {31'd0, l_req}, 32'd1);
    txn(1'b0, 2'd2, 20, 32'h0, rd, ak, nk, lc);
    chk(rd == wd, "R9", "read sees posted data", rd, wd);
    chk(lc - lc0 == 4 && lg_we[lc0] && lg_we[lc0+1] && !lg_we[lc0+2] && !lg_we[lc0+3],
        "R9", "read cycles after write cycles", 32'(lc - lc0), 32'd4);

    drain();
    summary();
  end
endmodule